// File: doc/BRIEF.md
# Time-Multiplexed Rotor Cipher Engine

This block enciphers one letter code (0 to 25, A to Z) at a time through a three-slot rotor machine with a fixed B-type reflector. It does not use three separate rotor circuits. A single mapping unit is reused over seven consecutive cycles: the right, middle and left slots going forward, the reflector, and then the left, middle and right slots going backward through the inverse wiring. On each pass the unit takes the rotor type, ring setting and position of the slot it is serving.

The block holds the per-slot configuration, which is the rotor type, the ring setting and the current position. All three are loaded together with a configuration strobe while the block is idle. A start strobe first steps the rotors, then launches the seven passes. A one-cycle done pulse marks the moment the result letter is valid. The current rotor positions are always visible on an output, so the surrounding logic can show the rotor windows. Plugboard substitution, command decoding and any display sit outside this block.

Top module: `rotor_cipher`

## Requirements
- R1: After reset, the slots hold types 0, 1 and 2 from right (slot 0) to left (slot 2). All rings and positions are 0, and busy_o and done_o are low. Type codes 0 to 4 stand for rotors I to V.
- R2: A cfg_load_i accepted while idle loads type_i, ring_i and pos_i for every slot. Slot k uses bits [3k+2:3k] of type_i and bits [5k+4:5k] of ring_i and pos_i. The loaded positions appear on pos_o, using the same packing, on the next cycle.
- R3: An accepted start advances the right slot position by one, modulo 26, before enciphering.
- R4: The middle slot advances when the right slot was at its notch before the step. The notches for types 0 to 4 are 16, 4, 21, 9 and 25.
- R5: When the middle slot was at its notch, both the middle and the left slot advance (double step).
- R6: The result is the input passed forward through slots 0, 1 and 2, then through the reflector, then backward through slots 2, 1 and 0. Each rotor pass uses the stepped positions and a shift s = (position - ring) mod 26, computed as out = W((in + s) mod 26) - s mod 26. W is the forward wiring going forward and the inverse wiring going backward. The forward wirings of types 0 to 4, mapping A to Z, are EKMFLGDQVZNTOWYHXUSPAIBRCJ, AJDKSIRUXBLHWTMCQGZNPYFVOE, BDFHJLCPRTXVZNYEIWGAKMUSQO, ESOVPZJAYQUIRHXLNFTGKDCMWB and VZBRGITYUPSDNHLXAWMKJQOFEC. The reflector is YRUHQSLDPXNGOKMIEBFZCWVJAT.
- R7: done_o is high for exactly one cycle, in the 7th cycle after the edge that accepts start. result_o keeps its value until the next done.
- R8: A start that arrives while busy_o is high is ignored: it gives no extra done pulse and no extra step.
- R9: A cfg_load_i that arrives while busy_o is high is ignored, and pos_o stays unchanged.
- R10: When cfg_load_i and start_i are both high in the same idle cycle, the configuration is loaded and the start is dropped. No encipherment runs and the positions do not step.
- R11: A letter never enciphers to itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to encipher letter_i |
| letter_i | input | 5 | Input letter code 0..25 |
| cfg_load_i | input | 1 | Load types, rings and positions |
| type_i | input | 9 | Rotor type per slot, 3 bits each |
| ring_i | input | 15 | Ring setting per slot, 5 bits each |
| pos_i | input | 15 | Start position per slot, 5 bits each |
| busy_o | output | 1 | Encipherment in progress |
| done_o | output | 1 | One-cycle pulse, result valid |
| result_o | output | 5 | Enciphered letter code |
| pos_o | output | 15 | Current rotor positions, 5 bits per slot |

## Verification
Two functions can collide in one cycle: a configuration load and the start of an encipherment, which both write the position registers. The bench raises both strobes on the same idle clock edge. It then checks that no done pulse follows for a dozen cycles, that pos_o shows the loaded positions unstepped, and that the next letter matches a model started from the freshly loaded state. A second test raises both strobes again partway through a running encipherment and expects exactly one done pulse and no change to the configuration.

// File: rtl/cipher_pkg.sv
package cipher_pkg;
  localparam int unsigned LW     = 5;
  localparam int unsigned TW     = 3;
  localparam int unsigned NLET   = 26;
  localparam int unsigned NTYPES = 5;

  typedef enum logic [1:0] {MAP_FWD, MAP_REFL, MAP_BWD} map_mode_e;

  localparam logic [8*NLET-1:0] ROW_T0  = "EKMFLGDQVZNTOWYHXUSPAIBRCJ";
  localparam logic [8*NLET-1:0] ROW_T1  = "AJDKSIRUXBLHWTMCQGZNPYFVOE";
  localparam logic [8*NLET-1:0] ROW_T2  = "BDFHJLCPRTXVZNYEIWGAKMUSQO";
  localparam logic [8*NLET-1:0] ROW_T3  = "ESOVPZJAYQUIRHXLNFTGKDCMWB";
  localparam logic [8*NLET-1:0] ROW_T4  = "VZBRGITYUPSDNHLXAWMKJQOFEC";
  localparam logic [8*NLET-1:0] ROW_REF = "YRUHQSLDPXNGOKMIEBFZCWVJAT";

  function automatic logic [LW-1:0] add26(input logic [LW-1:0] a, input logic [LW-1:0] b);
    logic [LW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s >= (LW+1)'(NLET)) ? LW'(s - (LW+1)'(NLET)) : LW'(s);
  endfunction

  function automatic logic [LW-1:0] sub26(input logic [LW-1:0] a, input logic [LW-1:0] b);
    return (a >= b) ? LW'(a - b) : LW'(a + LW'(NLET) - b);
  endfunction

  function automatic logic [LW-1:0] pick(input logic [8*NLET-1:0] row, input logic [LW-1:0] x);
    logic [7:0] c;
    if (x >= LW'(NLET)) return x;
    c = row[8*(NLET-1-int'(x)) +: 8];
    return LW'(c - 8'd65);
  endfunction

  function automatic logic [LW-1:0] wire_fwd(input logic [TW-1:0] t, input logic [LW-1:0] x);
    case (t)
      3'd0:    return pick(ROW_T0, x);
      3'd1:    return pick(ROW_T1, x);
      3'd2:    return pick(ROW_T2, x);
      3'd3:    return pick(ROW_T3, x);
      3'd4:    return pick(ROW_T4, x);
      default: return x;
    endcase
  endfunction

  function automatic logic [LW-1:0] wire_inv(input logic [TW-1:0] t, input logic [LW-1:0] x);
    logic [LW-1:0] r;
    r = x;
    for (int j = 0; j < int'(NLET); j++)
      if (wire_fwd(t, LW'(j)) == x) r = LW'(j);
    return r;
  endfunction

  function automatic logic [LW-1:0] reflect(input logic [LW-1:0] x);
    return pick(ROW_REF, x);
  endfunction

  function automatic logic [LW-1:0] notch_of(input logic [TW-1:0] t);
    case (t)
      3'd0:    return 5'd16;
      3'd1:    return 5'd4;
      3'd2:    return 5'd21;
      3'd3:    return 5'd9;
      default: return 5'd25;
    endcase
  endfunction
endpackage

// File: rtl/rotor_map.sv
module rotor_map
  import cipher_pkg::*;
(
  input  logic [LW-1:0] x,
  input  logic [TW-1:0] rtype,
  input  logic [LW-1:0] pos,
  input  logic [LW-1:0] ring,
  input  map_mode_e     mode,
  output logic [LW-1:0] y
);
  logic [LW-1:0] shift, entry, core;

  always_comb begin
    shift = sub26(pos, ring);
    entry = add26(x, shift);
    core  = (mode == MAP_BWD) ? wire_inv(rtype, entry) : wire_fwd(rtype, entry);
    y     = (mode == MAP_REFL) ? reflect(x) : sub26(core, shift);
  end
endmodule

// File: rtl/rotor_stepper.sv
module rotor_stepper
  import cipher_pkg::*;
#(
  parameter int unsigned NSLOT = 3
) (
  input  logic [NSLOT-1:0][TW-1:0] typ,
  input  logic [NSLOT-1:0][LW-1:0] pos,
  output logic [NSLOT-1:0][LW-1:0] pos_nxt
);
  logic [NSLOT-1:0] at_notch, advance;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    assign at_notch[k] = (pos[k] == notch_of(typ[k]));
    if (k == 0) begin : g_right
      assign advance[k] = 1'b1;
    end else if (k == NSLOT-1) begin : g_left
      assign advance[k] = at_notch[k-1];
    end else begin : g_mid
      assign advance[k] = at_notch[k-1] | at_notch[k];
    end
    assign pos_nxt[k] = advance[k] ? add26(pos[k], LW'(1)) : pos[k];
  end
endmodule

// File: rtl/rotor_cipher.sv
module rotor_cipher
  import cipher_pkg::*;
#(
  parameter int unsigned NSLOT = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [LW-1:0]       letter_i,
  input  logic                cfg_load_i,
  input  logic [NSLOT*TW-1:0] type_i,
  input  logic [NSLOT*LW-1:0] ring_i,
  input  logic [NSLOT*LW-1:0] pos_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [LW-1:0]       result_o,
  output logic [NSLOT*LW-1:0] pos_o
);
  localparam int unsigned NPASS = 2*NSLOT + 1;
  localparam int unsigned PW    = $clog2(NPASS);
  localparam int unsigned SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [NSLOT-1:0][TW-1:0] typ_q;
  logic [NSLOT-1:0][LW-1:0] ring_q, pos_q, pos_step;
  logic                     busy_q, done_q;
  logic [PW-1:0]            pass_q;
  logic [LW-1:0]            work_q, result_q, map_y;
  logic [SW-1:0]            sel;
  map_mode_e                mode;

  // named internal events
  logic start_acc, cfg_acc, last_pass;
  assign start_acc = start_i & ~busy_q & ~cfg_load_i;
  assign cfg_acc   = cfg_load_i & ~busy_q;
  assign last_pass = busy_q & (pass_q == PW'(NPASS-1));

  always_comb begin
    if (pass_q < PW'(NSLOT)) begin
      sel  = SW'(pass_q);
      mode = MAP_FWD;
    end else if (pass_q == PW'(NSLOT)) begin
      sel  = '0;
      mode = MAP_REFL;
    end else begin
      sel  = SW'(PW'(NPASS-1) - pass_q);
      mode = MAP_BWD;
    end
  end

  rotor_map u_map (
    .x     (work_q),
    .rtype (typ_q[sel]),
    .pos   (pos_q[sel]),
    .ring  (ring_q[sel]),
    .mode  (mode),
    .y     (map_y)
  );

  rotor_stepper #(.NSLOT(NSLOT)) u_step (
    .typ     (typ_q),
    .pos     (pos_q),
    .pos_nxt (pos_step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < int'(NSLOT); k++) begin
        typ_q[k]  <= TW'(k % int'(NTYPES));
        ring_q[k] <= '0;
        pos_q[k]  <= '0;
      end
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      pass_q   <= '0;
      work_q   <= '0;
      result_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (cfg_acc) begin
        for (int k = 0; k < int'(NSLOT); k++) begin
          typ_q[k]  <= type_i[k*TW +: TW];
          ring_q[k] <= ring_i[k*LW +: LW];
          pos_q[k]  <= pos_i[k*LW +: LW];
        end
      end else if (start_acc) begin
        pos_q  <= pos_step;
        work_q <= letter_i;
        pass_q <= '0;
        busy_q <= 1'b1;
      end
      if (busy_q) begin
        work_q <= map_y;
        pass_q <= pass_q + PW'(1);
        if (last_pass) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          result_q <= map_y;
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = result_q;
  for (genvar k = 0; k < NSLOT; k++) begin : g_pos_out
    assign pos_o[k*LW +: LW] = pos_q[k];
  end
endmodule

// File: rtl/rotor_cipher_chk.sv
module rotor_cipher_chk #(
  parameter int unsigned NSLOT = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic [4:0]          letter_i,
  input logic                cfg_load_i,
  input logic                busy_o,
  input logic                done_o,
  input logic [4:0]          result_o,
  input logic [NSLOT*5-1:0]  pos_o,
  input logic                start_acc
);
  localparam int unsigned NPASS = 2*NSLOT + 1;

  logic [3:0] lat_q;
  logic [4:0] let_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      let_q <= '0;
    end else if (start_acc) begin
      lat_q <= '0;
      let_q <= letter_i;
    end else if (busy_o) begin
      lat_q <= lat_q + 4'd1;
    end
  end

  p_done_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (lat_q == 4'(NPASS)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_right_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> pos_o[4:0] == (($past(pos_o[4:0]) == 5'd25) ? 5'd0 : $past(pos_o[4:0]) + 5'd1));

  p_busy_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(pos_o));

  p_cfg_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cfg_load_i) |=> $stable(pos_o));

  p_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && cfg_load_i) |=> !busy_o);

  p_no_self_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (result_o != let_q));
endmodule

bind rotor_cipher rotor_cipher_chk #(.NSLOT(NSLOT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .letter_i   (letter_i),
  .cfg_load_i (cfg_load_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .result_o   (result_o),
  .pos_o      (pos_o),
  .start_acc  (start_acc)
);

// File: tb/test_rotor_cipher.sv
module test_rotor_cipher;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [4:0]  letter_i = '0;
  logic        cfg_load_i = 1'b0;
  logic [8:0]  type_i = '0;
  logic [14:0] ring_i = '0;
  logic [14:0] pos_i = '0;
  logic        busy_o, done_o;
  logic [4:0]  result_o;
  logic [14:0] pos_o;

  int total = 0;
  int bad = 0;

  string wir [5] = '{"EKMFLGDQVZNTOWYHXUSPAIBRCJ", "AJDKSIRUXBLHWTMCQGZNPYFVOE",
                     "BDFHJLCPRTXVZNYEIWGAKMUSQO", "ESOVPZJAYQUIRHXLNFTGKDCMWB",
                     "VZBRGITYUPSDNHLXAWMKJQOFEC"};
  string refl = "YRUHQSLDPXNGOKMIEBFZCWVJAT";
  int nt [5] = '{16, 4, 21, 9, 25};
  int mtyp [3];
  int mring [3];
  int mpos [3];
  string step_tag;

  always #(PERIOD/2) clk = ~clk;

  rotor_cipher i_rotor_cipher (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .letter_i(letter_i),
    .cfg_load_i(cfg_load_i), .type_i(type_i), .ring_i(ring_i), .pos_i(pos_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .pos_o(pos_o)
  );

  function automatic int md(int v);
    return ((v % 26) + 26) % 26;
  endfunction

  function automatic int rf(int t, int x);
    return int'(wir[t].getc(x)) - 65;
  endfunction

  function automatic int ri(int t, int x);
    for (int j = 0; j < 26; j++) if (rf(t, j) == x) return j;
    return -1;
  endfunction

  function automatic int one_pass(int s, int v, bit back);
    int sh = md(mpos[s] - mring[s]);
    int a = md(v + sh);
    int w = back ? ri(mtyp[s], a) : rf(mtyp[s], a);
    return md(w - sh);
  endfunction

  function automatic int model_enc(int l);
    int v = l;
    for (int s = 0; s < 3; s++) v = one_pass(s, v, 1'b0);
    v = int'(refl.getc(v)) - 65;
    for (int s = 2; s >= 0; s--) v = one_pass(s, v, 1'b1);
    return v;
  endfunction

  task automatic model_step();
    bit mid_at = (mpos[1] == nt[mtyp[1]]);
    bit rgt_at = (mpos[0] == nt[mtyp[0]]);
    step_tag = "R3";
    if (mid_at) begin
      mpos[2] = md(mpos[2] + 1);
      mpos[1] = md(mpos[1] + 1);
      step_tag = "R5";
    end else if (rgt_at) begin
      mpos[1] = md(mpos[1] + 1);
      step_tag = "R4";
    end
    mpos[0] = md(mpos[0] + 1);
  endtask

  function automatic int mpacked();
    return mpos[0] + 32*mpos[1] + 1024*mpos[2];
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic load_cfg(int t0, int t1, int t2, int g0, int g1, int g2, int p0, int p1, int p2);
    @(negedge clk);
    cfg_load_i = 1'b1;
    type_i = 9'(t0 + 8*t1 + 64*t2);
    ring_i = 15'(g0 + 32*g1 + 1024*g2);
    pos_i  = 15'(p0 + 32*p1 + 1024*p2);
    mtyp = '{t0, t1, t2}; mring = '{g0, g1, g2}; mpos = '{p0, p1, p2};
    @(negedge clk);
    cfg_load_i = 1'b0;
    check(int'(pos_o) == mpacked(), "R2 positions loaded", int'(pos_o), mpacked());
  endtask

  // drives one letter, returns the letter seen on result_o
  task automatic do_char(int l, output int got);
    int exp, lat;
    model_step();
    exp = model_enc(l);
    @(negedge clk);
    start_i = 1'b1;
    letter_i = 5'(l);
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 7, "R7 latency", lat, 7);
    check(int'(result_o) == exp, "R6 result", int'(result_o), exp);
    check(int'(result_o) != l, "R11 not itself", int'(result_o), l);
    check(int'(pos_o) == mpacked(), step_tag, int'(pos_o), mpacked());
    got = int'(result_o);
    @(negedge clk);
    check(!done_o, "R7 single pulse", int'(done_o), 0);
    check(int'(result_o) == exp, "R7 result held", int'(result_o), exp);
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int got, dn, exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(pos_o == 15'd0, "R1 positions", int'(pos_o), 0);
    check(!busy_o && !done_o, "R1 idle", int'({busy_o, done_o}), 0);
    mtyp = '{0, 1, 2}; mring = '{0, 0, 0}; mpos = '{0, 0, 0};
    for (int i = 0; i < 26; i++) do_char(i, got);   // R1 default types via model

    // R6 known answer: right III, middle II, left I, AAAAA -> BDZGO
    load_cfg(2, 1, 0, 0, 0, 0, 0, 0, 0);
    begin
      int kat [5] = '{1, 3, 25, 6, 14};
      for (int i = 0; i < 5; i++) begin
        do_char(0, got);
        check(got == kat[i], "R6 known answer", got, kat[i]);
      end
    end

    // R5 double step from A D U
    load_cfg(2, 1, 0, 0, 0, 0, 20, 3, 0);
    for (int i = 0; i < 3; i++) do_char(i + 4, got);
    check(pos_o == 15'(23 + 32*5 + 1024*1), "R5 double step BFX", int'(pos_o), 23 + 32*5 + 1024);

    // rings and notches near wrap
    load_cfg(4, 3, 1, 5, 17, 11, 24, 8, 25);
    for (int i = 0; i < 60; i++) do_char((i * 7) % 26, got);

    // every type in every slot
    for (int t = 0; t < 5; t++) begin
      load_cfg(t, (t + 2) % 5, (t + 4) % 5, t * 3, t + 1, 25 - t, 15, 3 + t, t * 5);
      for (int i = 0; i < 26; i++) do_char(i, got);
    end

    // R8 / R9: start and load while busy are ignored
    model_step();
    exp = model_enc(9);
    @(negedge clk); start_i = 1'b1; letter_i = 5'd9;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk); start_i = 1'b1; letter_i = 5'd2; cfg_load_i = 1'b1; pos_i = 15'h1234; type_i = 9'h0;
    @(negedge clk); start_i = 1'b0; cfg_load_i = 1'b0;
    check(int'(pos_o) == mpacked(), "R9 load while busy", int'(pos_o), mpacked());
    dn = 0;
    for (int i = 0; i < 20; i++) begin
      if (done_o) begin
        dn++;
        check(int'(result_o) == exp, "R8 result unchanged", int'(result_o), exp);
      end
      @(negedge clk);
    end
    check(dn == 1, "R8 one done", dn, 1);
    check(int'(pos_o) == mpacked(), "R8 no extra step", int'(pos_o), mpacked());

    // R10 collision: load and start in the same idle cycle
    @(negedge clk);
    cfg_load_i = 1'b1; start_i = 1'b1; letter_i = 5'd3;
    type_i = 9'(3 + 8*0 + 64*4); ring_i = 15'(1 + 32*2 + 1024*3); pos_i = 15'(7 + 32*9 + 1024*11);
    mtyp = '{3, 0, 4}; mring = '{1, 2, 3}; mpos = '{7, 9, 11};
    @(negedge clk);
    cfg_load_i = 1'b0; start_i = 1'b0;
    dn = 0;
    for (int i = 0; i < 12; i++) begin
      dn += int'(done_o) + int'(busy_o);
      @(negedge clk);
    end
    check(dn == 0, "R10 start dropped", dn, 0);
    check(int'(pos_o) == mpacked(), "R10 loaded unstepped", int'(pos_o), mpacked());
    for (int i = 0; i < 4; i++) do_char(i + 20, got);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule